// File: doc/BRIEF.md
# Two-Class Thread Issue Scheduler

This block picks, in every clock cycle, at most one of eight hardware threads to issue an instruction into a five-stage barrel pipeline. Each thread brings a runnable flag and a priority-mode flag. A thread holds only one instruction in the pipeline at a time, so once it issues it must wait five cycles before it can issue again. The block drives a one-hot grant vector, combinational from the current inputs and state, and a valid flag. A cycle with no eligible thread is a bubble.

Threads in priority mode win the slot over normal threads. The normal group is still protected: after four priority grants in a row, an eligible normal thread takes the next slot. Any number of threads may be in priority mode, and the outcome stays deterministic. Each class picks among its own eligible threads in round-robin order. When no normal thread can issue, no slot is held back for the normal group.

Top module: `thread_slot_sched`

## Requirements
- R1: `grant_o` has at most one bit set, and `grant_valid_o` is high exactly when one bit is set. Bit i of `grant_o` selects thread i.
- R2: A thread granted in cycle t is not granted in cycles t+1 to t+4. It is eligible again from cycle t+5.
- R3: A thread is eligible when its `runnable_i` bit is 1 and its spacing from R2 has elapsed. When any eligible thread has its `prio_mode_i` bit at 1, a priority thread gets the slot, except in the case covered by R5.
- R4: Each class chooses the first eligible thread of that class, starting at its own pointer and counting upward with wrap-around. A class pointer moves to one past the granted thread only when that class wins the slot. Both pointers are 0 after reset.
- R5: After four priority grants in a row, with bubble cycles not breaking the run, an eligible normal thread gets the slot. Any normal grant restarts the run count at zero.
- R6: When no normal thread is eligible, no slot is held back. With five threads that are all priority and all runnable, there is a grant every cycle, and each thread issues once every five cycles.
- R7: When no thread is eligible, `grant_valid_o` is 0 and `grant_o` is all zeros. This includes the cycles just after reset while no thread is runnable.
- R8: A thread whose `runnable_i` bit is 0 is never granted. After the bit returns to 1, the thread is granted only once its five-cycle spacing has also elapsed.
- R9: With threads 0 to 6 in priority mode, thread 7 normal, and all eight runnable from reset, the first fifteen grants are 0,1,2,3,7,4,5,6,0,7,1,2,3,4,7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| runnable_i | input | 8 | Per-thread flag: thread has an instruction ready |
| prio_mode_i | input | 8 | Per-thread class: 1 = priority, 0 = normal |
| grant_o | output | 8 | One-hot issue grant for the current cycle |
| grant_valid_o | output | 1 | A thread issues in this cycle |

## Verification
The bench runs every one of the 256 priority masks with all threads runnable, and then again with pseudo-random runnable patterns. A design that lost the starvation guard would let seven priority threads lock out the normal thread. A design that reserved a normal slot when none was needed would insert bubbles in the five-priority-thread case. A design that advanced both pointers on every grant would break the fixed seven-plus-one issue order. A directed case drops a thread's runnable flag while that thread is cooling down. An early re-grant there shows a spacing counter that is cleared by the flag instead of by time.

// File: rtl/sched_pkg.sv
package sched_pkg;

    // Which class owns the current issue slot
    typedef enum logic [1:0] {
        SLOT_NONE = 2'd0,
        SLOT_PRIO = 2'd1,
        SLOT_NORM = 2'd2
    } slot_class_e;

endpackage

// File: rtl/slot_timer.sv
// Per-thread spacing counter: thread is ready once DEPTH cycles have passed since its last issue.
module slot_timer #(
    parameter int unsigned DEPTH = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic issue_i,
    output logic ready_o
);
    localparam int unsigned CW = (DEPTH > 2) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
    } timer_t;

    timer_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (issue_i) begin
            st_d.cnt = CW'(DEPTH - 1);
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
        ready_o = (st_q.cnt == '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R2: the arbiter never issues a thread whose previous instruction is still in flight
    a_r2_issue_only_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        issue_i |-> (st_q.cnt == '0));

    // R2: an issue makes the thread unavailable in the following cycle
    a_r2_busy_after_issue: assert property (@(posedge clk) disable iff (!rst_n)
        issue_i |=> !ready_o);

endmodule

// File: rtl/rr_picker.sv
// Round-robin choice within one class; the pointer moves only when this class wins.
module rr_picker #(
    parameter int unsigned N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req_i,
    input  logic         win_i,
    output logic [N-1:0] gnt_o,
    output logic         any_o
);
    localparam int unsigned IW = (N > 1) ? $clog2(N) : 1;

    typedef struct packed {
        logic [IW-1:0] ptr;
    } rr_t;

    rr_t           st_d, st_q;
    logic [IW-1:0] sel;
    logic          found;
    int            idx;

    always_comb begin
        st_d  = st_q;
        sel   = '0;
        found = 1'b0;
        idx   = 0;
        for (int off = 0; off < int'(N); off++) begin
            idx = int'(st_q.ptr) + off;
            if (idx >= int'(N)) idx = idx - int'(N);
            if (!found && req_i[idx]) begin
                found = 1'b1;
                sel   = IW'(idx);
            end
        end
        gnt_o = found ? (N'(1) << sel) : '0;
        any_o = found;
        if (win_i && found) begin
            st_d.ptr = (sel == IW'(N - 1)) ? '0 : sel + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R4: a class that does not own the slot keeps its pointer
    a_r4_pointer_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !win_i |=> $stable(st_q.ptr));

    // R4: the choice is always one of the requesters
    a_r4_grant_subset: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_o & ~req_i) == '0);

endmodule

// File: rtl/thread_slot_sched.sv
module thread_slot_sched #(
    parameter int unsigned NUM_THREADS = 8,
    parameter int unsigned PIPE_DEPTH  = 5
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_THREADS-1:0] runnable_i,
    input  logic [NUM_THREADS-1:0] prio_mode_i,
    output logic [NUM_THREADS-1:0] grant_o,
    output logic                   grant_valid_o
);
    import sched_pkg::*;

    localparam int unsigned STREAK_MAX = PIPE_DEPTH - 1;
    localparam int unsigned SW = (PIPE_DEPTH > 2) ? $clog2(PIPE_DEPTH) : 1;

    typedef struct packed {
        logic [SW-1:0] streak;   // consecutive priority grants, saturating
    } sched_t;

    sched_t                 st_d, st_q;
    slot_class_e            cls;
    logic [NUM_THREADS-1:0] ready;
    logic [NUM_THREADS-1:0] elig, prio_req, norm_req;
    logic [NUM_THREADS-1:0] prio_gnt, norm_gnt;
    logic                   prio_any, norm_any;
    logic                   norm_turn;

    // Spacing counters, one per thread
    for (genvar t = 0; t < int'(NUM_THREADS); t++) begin : g_timer
        slot_timer #(.DEPTH(PIPE_DEPTH)) i_timer (
            .clk     (clk),
            .rst_n   (rst_n),
            .issue_i (grant_o[t]),
            .ready_o (ready[t])
        );
    end

    rr_picker #(.N(NUM_THREADS)) i_prio_rr (
        .clk   (clk),
        .rst_n (rst_n),
        .req_i (prio_req),
        .win_i (cls == SLOT_PRIO),
        .gnt_o (prio_gnt),
        .any_o (prio_any)
    );

    rr_picker #(.N(NUM_THREADS)) i_norm_rr (
        .clk   (clk),
        .rst_n (rst_n),
        .req_i (norm_req),
        .win_i (cls == SLOT_NORM),
        .gnt_o (norm_gnt),
        .any_o (norm_any)
    );

    always_comb begin
        st_d      = st_q;
        elig      = runnable_i & ready;
        prio_req  = elig & prio_mode_i;
        norm_req  = elig & ~prio_mode_i;
        norm_turn = (st_q.streak == SW'(STREAK_MAX)) && (|norm_req);

        if (norm_turn)        cls = SLOT_NORM;
        else if (|prio_req)   cls = SLOT_PRIO;
        else if (|norm_req)   cls = SLOT_NORM;
        else                  cls = SLOT_NONE;

        unique case (cls)
            SLOT_PRIO: grant_o = prio_gnt;
            SLOT_NORM: grant_o = norm_gnt;
            default:   grant_o = '0;
        endcase
        grant_valid_o = (cls != SLOT_NONE);

        if (cls == SLOT_NORM) begin
            st_d.streak = '0;
        end else if (cls == SLOT_PRIO && st_q.streak != SW'(STREAK_MAX)) begin
            st_d.streak = st_q.streak + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R1: at most one thread issues, and valid tracks it
    a_r1_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_o) && (grant_valid_o == (grant_o != '0)));

    // R3: an eligible priority thread wins unless the normal group is owed a slot
    a_r3_prio_first: assert property (@(posedge clk) disable iff (!rst_n)
        ((prio_req != '0) && !norm_turn) |-> ((grant_o & prio_mode_i) != '0));

    // R5: after a full run of priority grants an eligible normal thread issues
    a_r5_normal_turn: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.streak == SW'(STREAK_MAX)) && (norm_req != '0)) |-> ((grant_o & ~prio_mode_i) != '0));

    // R5: the run counter never passes its limit
    a_r5_streak_bound: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.streak <= SW'(STREAK_MAX));

    // R7: no bubble while some thread could issue
    a_r7_no_idle_bubble: assert property (@(posedge clk) disable iff (!rst_n)
        (elig != '0) |-> grant_valid_o);

    // R8: a thread that is not runnable never issues
    a_r8_runnable_only: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_o & ~runnable_i) == '0);

endmodule

// File: tb/test_thread_slot_sched.sv
module test_thread_slot_sched;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] runnable = '0;
    logic [7:0] prio_mode = '0;
    logic [7:0] grant;
    logic       grant_valid;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // model state
    int m_last[8];
    int m_pptr, m_nptr, m_streak, m_cyc;
    int obs_idx;
    logic [15:0] lfsr = 16'hACE1;

    always #5 clk = ~clk;

    thread_slot_sched #(.NUM_THREADS(8), .PIPE_DEPTH(5)) i_thread_slot_sched (
        .clk           (clk),
        .rst_n         (rst_n),
        .runnable_i    (runnable),
        .prio_mode_i   (prio_mode),
        .grant_o       (grant),
        .grant_valid_o (grant_valid)
    );

    function automatic int rr_first(input logic [7:0] mask, input int ptr);
        for (int off = 0; off < 8; off++) begin
            int i = (ptr + off) % 8;
            if (mask[i]) return i;
        end
        return -1;
    endfunction

    function automatic int decode(input logic [7:0] g);
        for (int i = 0; i < 8; i++) if (g[i]) return i;
        return -1;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 8; i++) m_last[i] = -100;
        m_pptr = 0; m_nptr = 0; m_streak = 0; m_cyc = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; runnable = '0; prio_mode = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
    endtask

    task automatic step(input logic [7:0] run, input logic [7:0] pm, input string tag);
        logic [7:0] elig, pe, ne, exp_g;
        int e_idx, a_idx, cls;
        string req;
        @(negedge clk);
        runnable = run; prio_mode = pm;
        #1;
        elig = '0;
        for (int i = 0; i < 8; i++) elig[i] = run[i] && (m_cyc - m_last[i] >= 5);
        pe = elig & pm; ne = elig & ~pm;
        if (m_streak >= 4 && ne != 0)  begin cls = 2; e_idx = rr_first(ne, m_nptr); req = "R5"; end
        else if (pe != 0)              begin cls = 1; e_idx = rr_first(pe, m_pptr); req = (ne != 0) ? "R3" : "R4"; end
        else if (ne != 0)              begin cls = 2; e_idx = rr_first(ne, m_nptr); req = "R4"; end
        else                           begin cls = 0; e_idx = -1; req = "R7"; end
        if (tag != "") req = tag;
        exp_g = (e_idx >= 0) ? (8'd1 << e_idx) : 8'd0;
        // R1 structural check
        checks++;
        if (!$onehot0(grant) || grant_valid !== (grant != 0)) begin
            errors++;
            $display("FAIL R1: grant=%b valid=%b, expected one-hot with matching valid", grant, grant_valid);
        end
        checks++;
        if (grant !== exp_g || grant_valid !== (e_idx >= 0)) begin
            errors++;
            $display("FAIL %s: cycle %0d grant=%b valid=%b, expected grant=%b valid=%b",
                     req, m_cyc, grant, grant_valid, exp_g, (e_idx >= 0));
        end
        a_idx = decode(grant);
        obs_idx = a_idx;
        if (a_idx >= 0 && (m_cyc - m_last[a_idx] < 5)) begin
            checks++; errors++;
            $display("FAIL R2: thread %0d granted %0d cycles after last issue, expected >= 5",
                     a_idx, m_cyc - m_last[a_idx]);
        end
        @(posedge clk);
        if (e_idx >= 0) begin
            m_last[e_idx] = m_cyc;
            if (cls == 1) begin
                m_pptr = (e_idx + 1) % 8;
                if (m_streak < 4) m_streak++;
            end else begin
                m_nptr = (e_idx + 1) % 8;
                m_streak = 0;
            end
        end
        m_cyc++;
    endtask

    task automatic expect_idx(input int act, input int exp, input string req);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: granted thread %0d, expected %0d", req, act, exp);
        end
    endtask

    initial begin : watchdog
        #2000000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        int seq9[15];
        int cnt6[8];
        int valid6;
        seq9 = '{0, 1, 2, 3, 7, 4, 5, 6, 0, 7, 1, 2, 3, 4, 7};

        // Reset state: nothing runnable -> bubble (R7), then thread 0 first (R4)
        do_reset();
        #1;
        checks++;
        if (grant !== 8'h00 || grant_valid !== 1'b0) begin
            errors++;
            $display("FAIL R7: after reset grant=%b valid=%b, expected 00000000 0", grant, grant_valid);
        end
        step(8'hFF, 8'h00, "R4");
        expect_idx(obs_idx, 0, "R4");

        // R9: seven priority threads and one normal
        do_reset();
        for (int k = 0; k < 15; k++) begin
            step(8'hFF, 8'h7F, "R9");
            expect_idx(obs_idx, seq9[k], "R9");
        end

        // R6: five priority threads alone, no reserved slot
        do_reset();
        for (int i = 0; i < 8; i++) cnt6[i] = 0;
        valid6 = 0;
        for (int k = 0; k < 20; k++) begin
            step(8'h1F, 8'h1F, "R6");
            if (obs_idx >= 0) begin cnt6[obs_idx]++; valid6++; end
        end
        expect_idx(valid6, 20, "R6");
        for (int i = 0; i < 5; i++) expect_idx(cnt6[i], 4, "R6");

        // R8: thread 2 drops runnable while in flight
        do_reset();
        step(8'h24, 8'h00, "R8");  expect_idx(obs_idx, 2, "R8");
        step(8'h20, 8'h00, "R8");  expect_idx(obs_idx, 5, "R8");
        step(8'h20, 8'h00, "R8");  expect_idx(obs_idx, -1, "R8");
        step(8'h24, 8'h00, "R8");  expect_idx(obs_idx, -1, "R8");
        step(8'h24, 8'h00, "R8");  expect_idx(obs_idx, -1, "R8");
        step(8'h24, 8'h00, "R8");  expect_idx(obs_idx, 2, "R8");
        step(8'h24, 8'h00, "R8");  expect_idx(obs_idx, 5, "R8");

        // R5: four priority plus one normal: normal every fifth slot
        do_reset();
        for (int k = 0; k < 10; k++) begin
            step(8'h8F, 8'h0F, "");
            if (k == 4 || k == 9) expect_idx(obs_idx, 7, "R5");
        end

        // Sweep of all priority masks, full then pseudo-random runnable
        for (int m = 0; m < 256; m++) begin
            do_reset();
            for (int k = 0; k < 15; k++) step(8'hFF, 8'(m), "");
            for (int k = 0; k < 15; k++) begin
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                step(lfsr[7:0] | lfsr[15:8], 8'(m), "");
            end
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule